// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Host Controller

This block sits on the clocked side of a chip and runs a 16-bit asynchronous pseudo-static RAM with a 20-bit word address and separate upper and lower byte strobes. Callers hand it word or single-byte reads and writes through a valid/ready command port. It answers every finished access with a one-cycle done strobe. On a read, the captured data comes with that strobe. Every memory-side delay is a count of clock cycles set by a parameter.

After reset the controller holds the memory deselected and awake for a long start-up wait. Only after that wait does it take commands. Between accesses the memory always rests in standby. No access may keep the memory selected past a fixed cycle cap, and any access length that would exceed the cap is clipped to it.

A level request drops the memory into its deep power-down state, but only from standby. When the request is released, the full start-up wait runs again. Back-pressure rules: `cmd_ready` is high only while the controller idles in standby and no power-down is requested. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. The caller keeps `cmd_valid` and the command fields steady until that edge.

Top module: `psram_host_ctrl`

## Requirements
- R1: After reset release, `mem_ce_n` and `mem_awake` stay high and `cmd_ready` stays low, and `cmd_ready` first rises INIT_CYC clock cycles after the release.
- R2: During a read, `mem_we_n`=1, `mem_oe_n`=0, `mem_ce_n`=0 and `mem_awake`=1. `cmd_be[1]` drives `mem_ub_n` low for bits 15:8 and `cmd_be[0]` drives `mem_lb_n` low for bits 7:0. `mem_dq_oe` stays 0.
- R3: A read keeps the memory selected for min(ACC_CYC, MAX_SEL_CYC) cycles and then samples `mem_dq_i`. `rsp_done` pulses for one cycle with `rsp_rdata`, and a byte lane that was not enabled returns 8'h00.
- R4: A write selects the memory with its byte strobes for one cycle with `mem_we_n` high. Then `mem_we_n` goes low for min(WR_SETUP_CYC, MAX_SEL_CYC-2) cycles while the write data is driven. `mem_oe_n` stays high for the whole write and whenever the bus is driven.
- R5: A write ends when `mem_we_n` rises (or `mem_ce_n`, if END_BY_CE=1), and the other strobe follows one cycle later. The write data stays driven and unchanged for WR_HOLD_CYC cycles from that edge. Then the drive is released and `rsp_done` pulses.
- R6: A byte write (`cmd_be` = 2'b10 or 2'b01) enables only its lane, so the other byte of the stored word is unchanged.
- R7: `mem_ce_n` is never low for more than MAX_SEL_CYC consecutive cycles.
- R8: After every access the memory returns to standby (`mem_ce_n`=1, `mem_awake`=1), and `rsp_done` is high for exactly one cycle.
- R9: While `pwr_down_req` is high, the memory enters deep power-down only from standby: a running access finishes first. In deep power-down, `mem_awake`=0, `mem_ce_n`=1, `mem_dq_oe`=0 and `cmd_ready`=0.
- R10: After `pwr_down_req` falls, `mem_awake` rises on the next clock edge. `cmd_ready` returns INIT_CYC+1 cycles after the release, with `mem_ce_n` and `mem_awake` high all the while.
- R11: A command with `cmd_be`=2'b00 is accepted, starts no access, and pulses `cmd_err` for one cycle. The stored data is unchanged.
- R12: The address and byte strobes are latched when a command is accepted and stay stable while the memory is selected.
- R13: `cmd_ready` is low during every access, during the start-up wait and during deep power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 20 | Word address |
| cmd_be | input | 2 | Byte lanes: bit 1 upper (15:8), bit 0 lower (7:0) |
| cmd_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle strobe at the end of an access |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` after a read |
| cmd_err | output | 1 | One-cycle pulse for a command with no byte lane |
| pwr_down_req | input | 1 | Level request for deep power-down |
| mem_addr | output | 20 | Memory address |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_awake | output | 1 | Low puts the memory in deep power-down |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_i | input | 16 | Data read from the memory |

## Verification
The bench runs with an access time longer than the selection cap, so every read is clipped. A controller that ignored the cap would hold the select low past the limit, and the run-length check catches it. Byte writes and single-lane reads go to a memory model that returns all-ones on disabled lanes. A design that let the other strobe fall, or that passed an unmasked lane, would show the wrong word or a non-zero byte. A power-down request raised in the middle of a read checks that the read ends with the memory awake. The exit wait is counted to the cycle, and a rejected zero-lane command is confirmed by reading the location back unchanged.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_DPD, ST_RD, ST_WSEL, ST_WPULSE, ST_WHOLD
  } pc_state_e;

  function automatic int unsigned pc_min(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic int unsigned pc_max(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/psram_wait_timer.sv
module psram_wait_timer #(
  parameter int          W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R1: a load always lands as the new count
  p_timer_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/psram_bus_io.sv
module psram_bus_io #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   wdata,
  input  logic            capture,
  input  logic [DW/8-1:0] lane_en,
  input  logic [DW-1:0]   dq_i,
  output logic [DW-1:0]   dq_o,
  output logic [DW-1:0]   rdata
);
  localparam int NB = DW / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dq_o <= '0;
    else if (load) dq_o <= wdata;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata[8*b +: 8] <= '0;
      else if (capture) rdata[8*b +: 8] <= lane_en[b] ? dq_i[8*b +: 8] : 8'h00;
    end
  end

  // R5: write data never changes while a capture is taking place
  p_no_load_on_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> $stable(dq_o));
endmodule

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 16,
  parameter int INIT_CYC     = 60000,
  parameter int MAX_SEL_CYC  = 180,
  parameter int ACC_CYC      = 14,
  parameter int WR_SETUP_CYC = 10,
  parameter int WR_HOLD_CYC  = 2,
  parameter bit END_BY_CE    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [1:0]    cmd_be,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic          cmd_err,
  input  logic          pwr_down_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_awake,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned RD_LEN = pc_min(ACC_CYC, MAX_SEL_CYC);
  localparam int unsigned WS_LEN = pc_min(WR_SETUP_CYC, MAX_SEL_CYC - 2);
  localparam int unsigned TMAX   = pc_max(pc_max(INIT_CYC, MAX_SEL_CYC),
                                          pc_max(WR_HOLD_CYC, pc_max(ACC_CYC, WR_SETUP_CYC)));
  localparam int TW = $clog2(TMAX + 1);
  localparam int SW = $clog2(MAX_SEL_CYC + 1) + 1;
  localparam int IW = $clog2(INIT_CYC + 1) + 1;
  localparam logic [TW-1:0] RD_LOAD   = TW'(RD_LEN - 1);
  localparam logic [TW-1:0] WS_LOAD   = TW'(WS_LEN - 1);
  localparam logic [TW-1:0] HOLD_LOAD = TW'(WR_HOLD_CYC - 1);
  localparam logic [TW-1:0] INIT_LOAD = TW'(INIT_CYC - 1);

  pc_state_e       state, nxt;
  logic            t_load, t_exp;
  logic [TW-1:0]   t_val;
  logic            accept, acc_ok, hold_first;
  logic [1:0]      be_q;
  logic            hold_ce_low, hold_we_low;

  assign cmd_ready = (state == ST_IDLE) && !pwr_down_req;
  assign accept    = cmd_ready && cmd_valid;
  assign acc_ok    = accept && (cmd_be != 2'b00);

  psram_wait_timer #(.W(TW), .RST_VAL(INIT_CYC - 1)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp));

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = '0;
    case (state)
      ST_INIT:   if (t_exp) nxt = ST_IDLE;
      ST_IDLE: begin
        if (pwr_down_req) nxt = ST_DPD;
        else if (acc_ok) begin
          if (cmd_write) nxt = ST_WSEL;
          else begin nxt = ST_RD; t_load = 1'b1; t_val = RD_LOAD; end
        end
      end
      ST_DPD:    if (!pwr_down_req) begin nxt = ST_INIT; t_load = 1'b1; t_val = INIT_LOAD; end
      ST_RD:     if (t_exp) nxt = ST_IDLE;
      ST_WSEL:   begin nxt = ST_WPULSE; t_load = 1'b1; t_val = WS_LOAD; end
      ST_WPULSE: if (t_exp) begin nxt = ST_WHOLD; t_load = 1'b1; t_val = HOLD_LOAD; end
      ST_WHOLD:  if (t_exp) nxt = ST_IDLE;
      default:   nxt = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_INIT;
      mem_addr   <= '0;
      be_q       <= '0;
      cmd_err    <= 1'b0;
      rsp_done   <= 1'b0;
      hold_first <= 1'b0;
    end else begin
      state      <= nxt;
      cmd_err    <= accept && (cmd_be == 2'b00);
      rsp_done   <= ((state == ST_RD) || (state == ST_WHOLD)) && t_exp;
      hold_first <= (state == ST_WPULSE) && t_exp;
      if (acc_ok) begin
        mem_addr <= cmd_addr;
        be_q     <= cmd_be;
      end
    end
  end

  psram_bus_io #(.DW(DW)) i_bus (
    .clk(clk), .rst_n(rst_n), .load(acc_ok && cmd_write), .wdata(cmd_wdata),
    .capture((state == ST_RD) && t_exp), .lane_en(be_q), .dq_i(mem_dq_i),
    .dq_o(mem_dq_o), .rdata(rsp_rdata));

  if (END_BY_CE) begin : g_end_ce
    assign hold_ce_low = 1'b0;
    assign hold_we_low = hold_first;
  end else begin : g_end_we
    assign hold_ce_low = hold_first;
    assign hold_we_low = 1'b0;
  end

  always_comb begin
    mem_ce_n  = 1'b1;
    mem_awake = 1'b1;
    mem_oe_n  = 1'b1;
    mem_we_n  = 1'b1;
    mem_ub_n  = 1'b1;
    mem_lb_n  = 1'b1;
    mem_dq_oe = 1'b0;
    case (state)
      ST_DPD:    mem_awake = 1'b0;
      ST_RD:     begin mem_ce_n = 1'b0; mem_oe_n = 1'b0;
                       mem_ub_n = ~be_q[1]; mem_lb_n = ~be_q[0]; end
      ST_WSEL:   begin mem_ce_n = 1'b0; mem_ub_n = ~be_q[1]; mem_lb_n = ~be_q[0]; end
      ST_WPULSE: begin mem_ce_n = 1'b0; mem_we_n = 1'b0; mem_dq_oe = 1'b1;
                       mem_ub_n = ~be_q[1]; mem_lb_n = ~be_q[0]; end
      ST_WHOLD:  begin mem_dq_oe = 1'b1; mem_ce_n = ~hold_ce_low; mem_we_n = ~hold_we_low;
                       mem_ub_n = ~be_q[1]; mem_lb_n = ~be_q[0]; end
      default:   ;
    endcase
  end

  // Checker state: run of selected cycles and cycles awake since power-up
  logic [SW-1:0] sel_run;
  logic [IW-1:0] awake_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_run   <= '0;
      awake_run <= '0;
    end else begin
      sel_run   <= mem_ce_n ? '0 : ((sel_run == '1) ? sel_run : sel_run + 1'b1);
      awake_run <= !mem_awake ? '0 : ((awake_run == '1) ? awake_run : awake_run + 1'b1);
    end
  end

  p_init_wait_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> awake_run >= IW'(INIT_CYC));
  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n && mem_dq_oe);
  p_drive_no_oe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  p_wdata_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe && $past(mem_dq_oe) |-> $stable(mem_dq_o));
  p_sel_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> sel_run < SW'(MAX_SEL_CYC));
  p_dpd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_awake |-> mem_ce_n && !mem_dq_oe && !cmd_ready);
  p_dpd_from_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_awake) |-> $past(mem_ce_n) && $past(state) == ST_IDLE);
  p_err_no_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> mem_ce_n);
  p_addr_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n && $past(!mem_ce_n) |-> $stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n));
  p_ready_standby_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> mem_ce_n && mem_awake);
endmodule

// File: tb/test_psram_host_ctrl.sv
module test_psram_host_ctrl;
  localparam int INIT_CYC = 40, MAX_SEL = 12, ACC = 14, WSET = 6, WHOLD = 2;
  localparam int RD_LEN = (ACC < MAX_SEL) ? ACC : MAX_SEL;
  localparam int WS_LEN = (WSET < MAX_SEL - 2) ? WSET : MAX_SEL - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, pwr_down_req = 1'b0;
  logic [19:0] cmd_addr = '0;
  logic [1:0]  cmd_be = '0;
  logic [15:0] cmd_wdata = '0;
  logic cmd_ready, rsp_done, cmd_err;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [19:0] mem_addr;
  logic mem_ce_n, mem_awake, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  psram_host_ctrl #(.INIT_CYC(INIT_CYC), .MAX_SEL_CYC(MAX_SEL), .ACC_CYC(ACC),
                    .WR_SETUP_CYC(WSET), .WR_HOLD_CYC(WHOLD), .END_BY_CE(1'b0)) i_psram_host_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_be(cmd_be), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cmd_err(cmd_err),
    .pwr_down_req(pwr_down_req), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_awake(mem_awake), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  // Memory model: disabled lanes float to all ones
  logic [15:0] mem [16];
  logic        p_wr = 1'b0, p_ub = 1'b1, p_lb = 1'b1;
  logic [3:0]  p_a = '0;
  logic [15:0] p_d = '0;
  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && mem_awake) ?
    {mem_ub_n ? 8'hFF : mem[mem_addr[3:0]][15:8], mem_lb_n ? 8'hFF : mem[mem_addr[3:0]][7:0]} : 16'hFFFF;

  always @(negedge clk) begin
    if (p_wr && (mem_we_n || mem_ce_n)) begin
      if (!p_ub) mem[p_a][15:8] = p_d[15:8];
      if (!p_lb) mem[p_a][7:0]  = p_d[7:0];
    end
    p_wr = !mem_we_n && !mem_ce_n && mem_awake;
    p_ub = mem_ub_n; p_lb = mem_lb_n; p_a = mem_addr[3:0]; p_d = mem_dq_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_be = be; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset_init();
    int lows = 0;
    chk(mem_ce_n && mem_awake, "R1", "selects high in reset", {mem_ce_n, mem_awake}, 2'b11);
    chk(!cmd_ready, "R1", "ready low in reset", cmd_ready, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    while (!cmd_ready && lows < 1000) begin
      if (!mem_ce_n || !mem_awake) chk(0, "R1", "select during init", {mem_ce_n, mem_awake}, 2'b11);
      lows++; @(negedge clk);
    end
    chk(lows == INIT_CYC - 1, "R1", "ready rises INIT_CYC cycles after release", lows + 1, INIT_CYC);
  endtask

  task automatic t_write(input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
    int ce_low = 0, we_low = 0, drv = 0, n = 0;
    bit bad_oe = 0, bad_d = 0, bad_be = 0, busy_rdy = 0, first_we = 0;
    issue(1'b1, a, be, d);
    while (!rsp_done && n < 100) begin
      if (n == 0) first_we = mem_we_n;
      if (!mem_ce_n) begin
        ce_low++;
        if (mem_ub_n != ~be[1] || mem_lb_n != ~be[0] || mem_addr != a) bad_be = 1;
      end
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) bad_oe = 1;
      if (mem_dq_oe) begin drv++; if (mem_dq_o != d) bad_d = 1; end
      if (cmd_ready) busy_rdy = 1;
      n++; @(negedge clk);
    end
    chk(first_we, "R4", "write opens with we_n high", first_we, 1);
    chk(we_low == WS_LEN, "R4", "we_n low cycles", we_low, WS_LEN);
    chk(!bad_oe, "R4", "oe_n high through write", bad_oe, 0);
    chk(!bad_d && drv == WS_LEN + WHOLD, "R5", "data driven steady through setup and hold", drv, WS_LEN + WHOLD);
    chk(ce_low == WS_LEN + 2 && ce_low <= MAX_SEL, "R7", "write selected cycles", ce_low, WS_LEN + 2);
    chk(!bad_be, "R12", "address and lanes held", bad_be, 0);
    chk(!busy_rdy, "R13", "ready low during write", busy_rdy, 0);
    @(negedge clk);
    chk(!rsp_done && mem_ce_n && mem_awake && !mem_dq_oe, "R8", "standby after write",
        {rsp_done, mem_ce_n, mem_awake, mem_dq_oe}, 4'b0110);
  endtask

  task automatic t_read(input logic [19:0] a, input logic [1:0] be, input logic [15:0] exp,
                        input bit pd_mid, input string req);
    int ce_low = 0, n = 0;
    bit bad_sig = 0, busy_rdy = 0, slept = 0;
    issue(1'b0, a, be, 16'h0);
    if (pd_mid) pwr_down_req = 1'b1;
    while (!rsp_done && n < 100) begin
      if (!mem_ce_n) begin
        ce_low++;
        if (mem_oe_n || !mem_we_n || mem_dq_oe || mem_ub_n != ~be[1] ||
            mem_lb_n != ~be[0] || mem_addr != a) bad_sig = 1;
      end
      if (!mem_awake) slept = 1;
      if (cmd_ready) busy_rdy = 1;
      n++; @(negedge clk);
    end
    chk(!bad_sig, "R2", "read pin levels", bad_sig, 0);
    chk(ce_low == RD_LEN, "R7", "read selected cycles clipped to cap", ce_low, RD_LEN);
    chk(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
    chk(!busy_rdy, "R13", "ready low during read", busy_rdy, 0);
    if (pd_mid) chk(!slept && mem_awake, "R9", "read completes awake", slept, 0);
    @(negedge clk);
    chk(!rsp_done && mem_ce_n, "R8", "done is one cycle and select released", {rsp_done, mem_ce_n}, 2'b01);
  endtask

  task automatic t_reject();
    issue(1'b1, 20'h5, 2'b00, 16'hDEAD);
    chk(cmd_err && mem_ce_n && cmd_ready, "R11", "error pulse, no select",
        {cmd_err, mem_ce_n, cmd_ready}, 3'b111);
    @(negedge clk);
    chk(!cmd_err && mem_ce_n, "R11", "error is one cycle", {cmd_err, mem_ce_n}, 2'b01);
    t_read(20'h5, 2'b11, 16'h5A5A, 1'b0, "R11");
  endtask

  task automatic t_dpd();
    int lows = 0;
    bit bad = 0;
    t_read(20'h3, 2'b11, 16'hAB34, 1'b1, "R9");
    chk(!mem_awake && mem_ce_n && !mem_dq_oe && !cmd_ready, "R9", "deep power-down pins",
        {mem_awake, mem_ce_n, mem_dq_oe, cmd_ready}, 4'b0100);
    repeat (5) @(negedge clk);
    chk(!mem_awake && !cmd_ready, "R9", "stays down while requested", {mem_awake, cmd_ready}, 0);
    pwr_down_req = 1'b0;
    @(negedge clk);
    while (!cmd_ready && lows < 1000) begin
      if (!mem_ce_n || !mem_awake) bad = 1;
      lows++; @(negedge clk);
    end
    chk(!bad, "R10", "selects high during restart wait", bad, 0);
    chk(lows == INIT_CYC, "R10", "ready after INIT_CYC+1 cycles", lows + 1, INIT_CYC + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_init();
    t_write(20'h3, 2'b11, 16'h1234);
    t_read(20'h3, 2'b11, 16'h1234, 1'b0, "R3");
    t_write(20'h5, 2'b11, 16'h5A5A);
    t_write(20'h3, 2'b10, 16'hABCD);
    t_read(20'h3, 2'b11, 16'hAB34, 1'b0, "R6");
    t_read(20'h3, 2'b01, 16'h0034, 1'b0, "R3");
    t_write(20'h5, 2'b01, 16'hFFC3);
    t_read(20'h5, 2'b11, 16'h5AC3, 1'b0, "R6");
    t_write(20'h5, 2'b11, 16'h5A5A);
    t_read(20'h5, 2'b10, 16'h5A00, 1'b0, "R3");
    t_reject();
    t_dpd();
    t_read(20'h5, 2'b11, 16'h5A5A, 1'b0, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule